// File: doc/BRIEF.md
# IO Address Translation Unit

This block turns 32-bit device DMA addresses into physical addresses by looking up a single-level page table that lives in system memory. Software programs it through a word-addressed register space of three 4 KiB pages: word 0 holds control (enable, mapping-range code, identification fields) and word 1 holds the page-table base. Every other word in the space is plain storage that reads back what was last written.

A device presents an address on a valid/ready request channel. When translation is enabled, the unit masks the window bits out of the address, forms the table entry address, issues one 32-bit read on a memory request/response port, and combines the returned entry with the page offset. The result leaves on a valid/ready response channel together with the entry's cacheable flag. When translation is disabled the address passes straight through one cycle after acceptance, with no memory traffic. Only one translation is in flight: `req_ready` is high only while the unit is idle, so a request waits until the previous result has been taken. On every output channel, valid and payload hold steady until the consumer's ready is seen high at a clock edge.

Top module: `iova_xlate`

## Requirements
- R1: After reset every register word reads zero, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R2: A write to any word index below 3072 is read back unchanged on `reg_rdata` (combinational read), including the identification bits 31:24 of word 0; writes to indices 3072 and above are dropped and those indices read zero.
- R3: A write to word 0 sets the window start to 0xFF000000 shifted left by the range code in bits 4:2, so code 0 gives 0xFF000000, code 6 gives 0xC0000000 and code 7 gives 0x80000000; the start is zero after reset.
- R4: With enable (word 0 bit 0) set, the memory read address is (word 1 << 4) + (((dva & ~start) >> 10) with bits 1:0 cleared), modulo 2^32.
- R5: The translated address is ((entry & 0x07FFFF00) << 4) + (dva bits 11:0): entry bits 26:8 land on physical bits 30:12 and bit 31 is zero.
- R6: `resp_cache` equals bit 7 of the returned entry and does not alter `resp_pa`; it is 0 in pass-through.
- R7: With enable clear, an accepted request gives `resp_valid` on the next cycle with `resp_pa` equal to the device address, and `mem_req_valid` stays 0.
- R8: `req_ready` is low from the cycle after acceptance until the response handshake completes.
- R9: `mem_req_valid` and `mem_addr` hold steady until `mem_req_ready` is seen high.
- R10: `resp_valid`, `resp_pa` and `resp_cache` hold steady until `resp_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_dva | input | 32 | Device address to translate |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Table entry byte address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 32 | Table entry |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_pa | output | 32 | Physical address |
| resp_cache | output | 1 | Cacheable flag from the entry |

## Verification
The hardest situation to reach is a table address that wraps past 2^32 while the window mask and the page index both sit at their extremes, because it needs an all-ones base, the largest range code and a device address at the top of the space at once. The stimulus sets up that corner directly, then sweeps every range code with random bases and addresses. Memory acceptance, response latency and consumer stalls are each randomised so that the hold rules on both output channels are exercised across several stall lengths.

// File: rtl/iova_pkg.sv
package iova_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MREQ,
    ST_MWAIT,
    ST_RESP
  } walk_st_e;

  // Window start: top-aligned mask, 16 MB doubled per code step.
  function automatic logic [WORD_W-1:0] window_start(input logic [2:0] code);
    return 32'hff00_0000 << code;
  endfunction
endpackage

// File: rtl/iova_regs.sv
module iova_regs
  import iova_pkg::*;
#(
  parameter int unsigned NWORDS   = 3072,
  parameter int unsigned AW       = 12,
  parameter int unsigned CTRL_IDX = 0,
  parameter int unsigned BASE_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              ctrl_en,
  output logic [WORD_W-1:0] tbl_base,
  output logic [WORD_W-1:0] win_start
);
  logic [WORD_W-1:0] words [NWORDS];
  logic [WORD_W-1:0] start_q;
  logic              in_range;

  assign in_range = 32'(addr) < NWORDS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NWORDS); i++) words[i] <= '0;
      start_q <= '0;
    end else if (wr_en && in_range) begin
      words[addr] <= wdata;
      if (32'(addr) == CTRL_IDX) start_q <= window_start(wdata[4:2]);
    end
  end

  assign rdata     = in_range ? words[addr] : '0;
  assign ctrl_en   = words[CTRL_IDX][0];
  assign tbl_base  = words[BASE_IDX];
  assign win_start = start_q;
endmodule

// File: rtl/iova_walk.sv
module iova_walk
  import iova_pkg::*;
#(
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned PN_LO  = 8,
  parameter int unsigned PN_HI  = 26,
  parameter int unsigned PN_SH  = 4,
  parameter int unsigned CA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] start,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_dva,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [WORD_W-1:0] resp_pa,
  output logic              resp_cache
);
  localparam logic [WORD_W-1:0] PN_MASK =
    ((WORD_W'(1) << (PN_HI - PN_LO + 1)) - 1) << PN_LO;

  walk_st_e          st_q;
  logic [WORD_W-1:0] addr_q, pa_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              cache_q;
  logic [WORD_W-1:0] masked, idx_ofs;

  assign masked  = req_dva & ~start;
  assign idx_ofs = (masked >> (OFS_W - 2)) & ~WORD_W'(3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      pa_q    <= '0;
      ofs_q   <= '0;
      cache_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          if (en) begin
            addr_q <= (base << 4) + idx_ofs;
            ofs_q  <= masked[OFS_W-1:0];
            st_q   <= ST_MREQ;
          end else begin
            pa_q    <= req_dva;
            cache_q <= 1'b0;
            st_q    <= ST_RESP;
          end
        end
        ST_MREQ:  if (mem_req_ready) st_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          pa_q    <= ((mem_rsp_data & PN_MASK) << PN_SH) + WORD_W'(ofs_q);
          cache_q <= mem_rsp_data[CA_BIT];
          st_q    <= ST_RESP;
        end
        ST_RESP:  if (resp_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = st_q == ST_IDLE;
  assign mem_req_valid = st_q == ST_MREQ;
  assign mem_addr      = addr_q;
  assign resp_valid    = st_q == ST_RESP;
  assign resp_pa       = pa_q;
  assign resp_cache    = cache_q;
endmodule

// File: rtl/iova_xlate.sv
module iova_xlate
  import iova_pkg::*;
#(
  parameter int unsigned PAGES      = 3,
  parameter int unsigned PAGE_WORDS = 1024,
  parameter int unsigned OFS_W      = 12,
  localparam int unsigned NWORDS    = PAGES * PAGE_WORDS,
  localparam int unsigned AW        = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_dva,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [WORD_W-1:0] resp_pa,
  output logic              resp_cache
);
  logic              ctrl_en;
  logic [WORD_W-1:0] tbl_base, win_start;

  iova_regs #(.NWORDS(NWORDS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_en(ctrl_en),
    .tbl_base(tbl_base), .win_start(win_start)
  );

  iova_walk #(.OFS_W(OFS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .base(tbl_base), .start(win_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_dva(req_dva),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_pa(resp_pa), .resp_cache(resp_cache)
  );
endmodule

// File: rtl/iova_xlate_chk.sv
module iova_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctrl_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_dva,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_addr,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_pa,
  input logic        resp_cache
);
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ctrl_en) |=>
      (resp_valid && !mem_req_valid && resp_pa == $past(req_dva) && !resp_cache));

  assert_busy_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);

  assert_busy_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_resp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_pa) && $stable(resp_cache)));

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req_valid, resp_valid}));
endmodule

bind iova_xlate iova_xlate_chk u_chk (.*);

// File: tb/iova_xlate_bench.sv
module iova_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_dva = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 0;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = '0;
  logic        resp_valid;
  logic        resp_ready = 0;
  logic [31:0] resp_pa;
  logic        resp_cache;

  int checks = 0, fails = 0;
  logic [31:0] m_ctrl = '0, m_base = '0, m_start = '0;
  logic [31:0] pte_force = '0;
  bit          use_force = 0;

  always #5 clk = ~clk;

  iova_xlate u_iova_xlate (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_entry(input logic [31:0] dva);
    logic [31:0] m;
    m = dva & ~m_start;
    return (m_base << 4) + ((m >> 10) & ~32'd3);
  endfunction

  function automatic logic [31:0] pte_of(input logic [31:0] ea);
    return (ea * 32'h9e37_79b1) ^ 32'h3c5a_0f81;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] pte, input logic [31:0] dva);
    return ((pte & 32'h07ff_ff00) << 4) + {20'd0, dva[11:0]};
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a == 0) begin m_ctrl = d; m_start = 32'hff00_0000 << d[4:2]; end
    if (a == 1) m_base = d;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == e, req, reg_rdata, e);
  endtask

  task automatic xlate(input logic [31:0] dva);
    logic [31:0] ea, pte, pa;
    bit c;
    ea = exp_entry(dva);
    pte = use_force ? pte_force : pte_of(ea);
    @(negedge clk); req_valid = 1; req_dva = dva;
    @(negedge clk); req_valid = 0;
    chk(!req_ready, "R8 ready low while busy", 32'(req_ready), 0);
    if (m_ctrl[0]) begin
      chk(mem_req_valid && mem_addr == ea, "R4 table address", mem_addr, ea);
      repeat ($urandom_range(0, 2)) begin
        @(negedge clk);
        chk(mem_req_valid && mem_addr == ea, "R9 mem request held", mem_addr, ea);
      end
      mem_req_ready = 1;
      @(negedge clk); mem_req_ready = 0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
      mem_rsp_valid = 1; mem_rsp_data = pte;
      @(negedge clk); mem_rsp_valid = 0;
      pa = exp_pa(pte, dva); c = pte[7];
    end else begin
      chk(!mem_req_valid, "R7 no memory read in bypass", 32'(mem_req_valid), 0);
      pa = dva; c = 0;
    end
    chk(resp_valid && resp_pa == pa, m_ctrl[0] ? "R5 physical address" : "R7 pass-through",
        resp_pa, pa);
    chk(resp_cache == c, "R6 cache flag", 32'(resp_cache), 32'(c));
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(resp_valid && resp_pa == pa && resp_cache == c, "R10 response held", resp_pa, pa);
    end
    resp_ready = 1;
    @(negedge clk); resp_ready = 0;
    chk(req_ready && !resp_valid, "R8 ready after handshake", 32'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20050406));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 idle after reset", 32'(req_ready), 1);
    rd_chk(0, 0, "R1 control zero");
    rd_chk(1, 0, "R1 base zero");
    rd_chk(3071, 0, "R1 last word zero");

    // R2 storage words
    for (int i = 0; i < 8; i++) begin
      logic [11:0] a; logic [31:0] d;
      a = 12'($urandom_range(2, 3071)); d = $urandom;
      wr(a, d);
      rd_chk(a, d, "R2 readback");
    end
    wr(12'd3072, 32'hdead_beef);
    rd_chk(12'd3072, 0, "R2 out of range ignored");
    wr(12'd4095, 32'h1234_5678);
    rd_chk(12'd4095, 0, "R2 out of range ignored");
    wr(0, 32'hA500_0000);
    rd_chk(0, 32'hA500_0000, "R2 id bits stored");

    // R7 bypass with translation disabled
    for (int i = 0; i < 4; i++) xlate($urandom);

    // R3..R6 every range code, random base and addresses
    for (int code = 0; code < 8; code++) begin
      wr(1, $urandom);
      wr(0, 32'hA500_0001 | (32'(code) << 2));
      for (int k = 0; k < 6; k++) xlate($urandom);
    end

    // Directed corners: wrap of table address, top-of-space dva
    wr(1, 32'hffff_ffff);
    wr(0, 32'h0000_001d);
    xlate(32'hffff_ffff);
    xlate(32'h8000_0000);
    wr(0, 32'h0000_0001);
    xlate(32'hff00_0fff);
    xlate(32'h00ff_f123);
    // R5/R6 entry with all bits set: bit 31 of pa stays clear
    use_force = 1; pte_force = 32'hffff_ffff;
    xlate(32'h0012_3abc);
    pte_force = 32'h0000_0080;
    xlate(32'h0000_0555);
    pte_force = 32'hffff_ff7f;
    xlate(32'h0000_0fff);
    use_force = 0;
    // R3 code 6 window: bit 30 cleared out of dva
    wr(1, 32'h0000_1000);
    wr(0, 32'h0000_0019);
    xlate(32'hc000_5000);
    // back to bypass
    wr(0, 32'h0000_0000);
    xlate(32'h8765_4321);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule